// File: doc/BRIEF.md
# Per-Channel Input Deglitch Filter

This block cleans up 24 digital inputs before the rest of the chip uses them. Every raw input first passes a two-flop synchronizer. A channel whose enable bit is set then passes a new level only after the synchronized input has held that level, away from the last accepted one, for a programmable number of base ticks. A channel whose enable bit is clear passes the synchronized input straight through. One interval, counted in 200 ns ticks, is shared by all channels.

Software reaches the block through a byte-wide register port. Three bytes hold a staged 20-bit interval. Three bytes hold the enable mask. A strobe register copies the staged interval into the active interval, or snaps every filtered channel to its present input. The filtered levels can be read back as three bytes, and they are also driven on a parallel output.

Register map (4-bit address): 0, 1, 2 hold the filtered levels for channels 0-7, 8-15 and 16-23 (read only). 4, 5, 6 hold the staged interval in low, middle and top parts. 8, 9, 10 hold the enable mask in low, middle and top parts. 12 is the strobe register, which is write-only and reads as zero. Any other address reads zero.

Top module: `deglitch_bank`

## Requirements
- R1: After reset the enable mask, the staged interval and the active interval are all zero, so every channel passes its synchronized input.
- R2: A channel with its enable bit clear shows on `filt_o` the value that `raw_i` had two rising clock edges earlier.
- R3: A base tick occurs on every TICK_DIV-th clock edge after reset is released (default 20 clocks, which is 200 ns at 100 MHz). Filter counts advance only on ticks.
- R4: An enabled channel whose active interval N is nonzero takes on a new synchronized level only after that level has differed from the accepted level on N consecutive ticks. If the input returns to the accepted level before then, the count restarts from zero, so a shorter glitch is rejected.
- R5: Writes to addresses 4, 5 and 6 load bits 7:0, 15:8 and 19:16 of the staged interval. Only bits 3:0 of a write to address 6 are kept. The staged value reads back at the same addresses, and it has no effect on filtering until it is applied.
- R6: A write to address 12 with bit 0 set copies the staged interval into the active interval. The active interval changes on no other write.
- R7: A write to address 12 with bit 1 set makes every enabled channel accept its current synchronized input on that edge and clears its count.
- R8: Writes to addresses 8, 9 and 10 load enable bits 7:0, 15:8 and 23:16. Bit i set turns on filtering for channel i. The mask reads back at the same addresses.
- R9: An enabled channel with an active interval of zero accepts a changed input on the next clock edge, without waiting for a tick.
- R10: Addresses 0, 1 and 2 read the filtered levels of channels 7:0, 15:8 and 23:16, with channel 0 in bit 0 of address 0. This matches `filt_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_i | input | 24 | Raw asynchronous inputs |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for read and write |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data, combinational from addr |
| filt_o | output | 24 | Filtered levels of all channels |

## Verification
Unfiltered channels are driven with a wide mixed pattern, which separates the two-edge synchronizer latency from passthrough with no delay. Filtered channels see a glitch shorter than the interval and then a level held longer than it, which shows both rejection and acceptance. Further runs stage a long interval without applying it, and show that it does not take effect. Using the snap strobe and a zero interval shows immediate acceptance against acceptance paced by the tick, and a reference model is compared with the filtered output on every clock.

// File: rtl/deglitch_bank.sv
module deglitch_bank #(
  parameter int TICK_DIV = 20,
  parameter int IVW      = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [23:0] raw_i,
  input  logic        wr_en,
  input  logic [3:0]  addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic [23:0] filt_o
);
  localparam int NCH  = 24;
  localparam int DW   = $clog2(TICK_DIV);
  localparam int TOPW = IVW - 16;
  localparam logic [IVW:0] ONE = (IVW+1)'(1);

  localparam logic [3:0] A_IN0 = 4'd0, A_IN1 = 4'd1, A_IN2 = 4'd2;
  localparam logic [3:0] A_IV0 = 4'd4, A_IV1 = 4'd5, A_IV2 = 4'd6;
  localparam logic [3:0] A_EN0 = 4'd8, A_EN1 = 4'd9, A_EN2 = 4'd10;
  localparam logic [3:0] A_CLR = 4'd12;

  logic [NCH-1:0] s1_q, sync_q, en_q;
  logic [IVW-1:0] stg_q, act_q;
  logic [DW-1:0]  div_q;
  logic           tick, clr_wr, snap;

  assign tick   = (div_q == DW'(TICK_DIV - 1));
  assign clr_wr = wr_en && (addr == A_CLR);
  assign snap   = clr_wr && wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      sync_q <= '0;
      div_q  <= '0;
    end else begin
      s1_q   <= raw_i;
      sync_q <= s1_q;
      div_q  <= tick ? '0 : div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
      en_q  <= '0;
      act_q <= '0;
    end else begin
      if (wr_en) begin
        case (addr)
          A_IV0: stg_q[7:0]      <= wdata;
          A_IV1: stg_q[15:8]     <= wdata;
          A_IV2: stg_q[IVW-1:16] <= wdata[TOPW-1:0];
          A_EN0: en_q[7:0]       <= wdata;
          A_EN1: en_q[15:8]      <= wdata;
          A_EN2: en_q[23:16]     <= wdata;
          default: ;
        endcase
      end
      if (clr_wr && wdata[0]) act_q <= stg_q;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [IVW-1:0] cnt_q;
    logic           acc_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q <= 1'b0;
        cnt_q <= '0;
      end else if (snap || !en_q[i] || sync_q[i] == acc_q || act_q == '0) begin
        acc_q <= sync_q[i];
        cnt_q <= '0;
      end else if (tick) begin
        if (({1'b0, cnt_q} + ONE) >= {1'b0, act_q}) begin
          acc_q <= sync_q[i];
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
    assign filt_o[i] = en_q[i] ? acc_q : sync_q[i];
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_IN0: rdata = filt_o[7:0];
      A_IN1: rdata = filt_o[15:8];
      A_IN2: rdata = filt_o[23:16];
      A_IV0: rdata = stg_q[7:0];
      A_IV1: rdata = stg_q[15:8];
      A_IV2: rdata[TOPW-1:0] = stg_q[IVW-1:16];
      A_EN0: rdata = en_q[7:0];
      A_EN1: rdata = en_q[15:8];
      A_EN2: rdata = en_q[23:16];
      default: ;
    endcase
  end
endmodule

// File: rtl/deglitch_bank_chk.sv
module deglitch_bank_chk #(
  parameter int IVW = 20
) (
  input logic           clk,
  input logic           rst_n,
  input logic [23:0]    raw_i,
  input logic           wr_en,
  input logic [3:0]     addr,
  input logic [7:0]     wdata,
  input logic [23:0]    filt_o,
  input logic [23:0]    en_q,
  input logic [IVW-1:0] stg_q,
  input logic [IVW-1:0] act_q,
  input logic           tick
);
  logic [1:0] cyc_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 1'b1;
  end

  // R2
  passthru_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q >= 2'd2) |-> ((filt_o & ~en_q) == ($past(raw_i, 2) & ~en_q)));

  // R4
  filt_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cyc_q >= 2'd1) && (((filt_o ^ $past(filt_o)) & en_q & $past(en_q)) != '0)
     && ($past(act_q) != '0))
    |-> ($past(tick) || $past(wr_en && addr == 4'd12 && wdata[1])));

  // R6
  apply_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'd12 && wdata[0]) |=> (act_q == $past(stg_q)));

  // R6
  apply_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 4'd12 && wdata[0]) |=> $stable(act_q));

  // R8
  en_low_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'd8) |=> (en_q[7:0] == $past(wdata)));

  // R5
  stg_top_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'd6) |=> (stg_q[IVW-1:16] == $past(wdata[IVW-17:0])));

  // R3
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

bind deglitch_bank deglitch_bank_chk #(.IVW(IVW)) u_chk (
  .clk(clk), .rst_n(rst_n), .raw_i(raw_i), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .filt_o(filt_o), .en_q(en_q), .stg_q(stg_q),
  .act_q(act_q), .tick(tick)
);

// File: tb/tb_deglitch_bank.sv
module tb_deglitch_bank;
  localparam int DIV = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] raw_i = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [23:0] filt_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  deglitch_bank #(.TICK_DIV(DIV), .IVW(20)) dut (
    .clk(clk), .rst_n(rst_n), .raw_i(raw_i), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .filt_o(filt_o)
  );

  // behavioural reference
  logic [23:0] m_s1, m_s2, m_en, m_acc;
  logic [19:0] m_stg, m_act;
  int          m_cnt [24];
  int          m_div;
  bit          m_tk, m_snap;

  function automatic logic [23:0] m_filt();
    logic [23:0] f;
    for (int i = 0; i < 24; i++) f[i] = m_en[i] ? m_acc[i] : m_s2[i];
    return f;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_en = '0; m_acc = '0; m_stg = '0; m_act = '0;
      m_div = 0;
      for (int i = 0; i < 24; i++) m_cnt[i] = 0;
    end else begin
      m_tk   = (m_div == DIV - 1);
      m_snap = wr_en && addr == 4'd12 && wdata[1];
      for (int i = 0; i < 24; i++) begin
        if (m_snap || !m_en[i] || m_s2[i] == m_acc[i] || m_act == 0) begin
          m_acc[i] = m_s2[i]; m_cnt[i] = 0;
        end else if (m_tk) begin
          m_cnt[i]++;
          if (m_cnt[i] >= int'(m_act)) begin m_acc[i] = m_s2[i]; m_cnt[i] = 0; end
        end
      end
      if (wr_en) begin
        case (addr)
          4'd4:  m_stg[7:0]   = wdata;
          4'd5:  m_stg[15:8]  = wdata;
          4'd6:  m_stg[19:16] = wdata[3:0];
          4'd8:  m_en[7:0]    = wdata;
          4'd9:  m_en[15:8]   = wdata;
          4'd10: m_en[23:16]  = wdata;
          4'd12: if (wdata[0]) m_act = m_stg;
          default: ;
        endcase
      end
      m_div = m_tk ? 0 : m_div + 1;
      m_s2 = m_s1;
      m_s1 = raw_i;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R4 R2 compare against the reference on every clock
  always @(negedge clk) if (rst_n && !done) check("R4", filt_o, m_filt());

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(4'd8, d);  check("R1", d, 8'h00);
    rd(4'd10, d); check("R1", d, 8'h00);
    rd(4'd6, d);  check("R1", d, 8'h00);
    check("R1", filt_o, 24'h0);

    // R2 passthrough latency
    raw_i = 24'hA5C33C;
    @(negedge clk); check("R2", filt_o, 24'h000000);
    @(negedge clk); check("R2", filt_o, 24'hA5C33C);
    rd(4'd0, d); check("R10", d, 8'h3C);
    rd(4'd1, d); check("R10", d, 8'hC3);
    rd(4'd2, d); check("R10", d, 8'hA5);
    raw_i = 24'h000000; cyc(3);

    // R5 staged interval, top part keeps 4 bits
    wr(4'd4, 8'h05); wr(4'd5, 8'h00); wr(4'd6, 8'hF3);
    rd(4'd6, d); check("R5", d, 8'h03);
    rd(4'd4, d); check("R5", d, 8'h05);
    wr(4'd6, 8'h00); wr(4'd4, 8'h03);
    wr(4'd12, 8'h01);  // R6 apply interval 3
    wr(4'd8, 8'hFF);   // R8 filter channels 0-7
    rd(4'd8, d); check("R8", d, 8'hFF);

    // R4 glitch shorter than interval is rejected
    raw_i[0] = 1'b1; cyc(25);
    raw_i[0] = 1'b0; cyc(30);
    check("R4", filt_o[0], 1'b0);
    // R4 held level accepted
    raw_i[0] = 1'b1; cyc(30);
    check("R4", filt_o[0], 1'b0);
    cyc(70);
    check("R4", filt_o[0], 1'b1);

    // R5 staged value without apply leaves interval at 3
    wr(4'd4, 8'h28);
    raw_i[3] = 1'b1; cyc(100);
    check("R5", filt_o[3], 1'b1);

    // R7 snap strobe
    raw_i[1] = 1'b1; cyc(4);
    @(negedge clk); wr_en = 1'b1; addr = 4'd12; wdata = 8'h02;
    @(negedge clk); wr_en = 1'b0;
    check("R7", filt_o[1], 1'b1);

    // R9 zero interval accepts on the next edge
    wr(4'd4, 8'h00); wr(4'd12, 8'h01);
    raw_i[2] = 1'b1;
    cyc(2); check("R9", filt_o[2], 1'b0);
    cyc(1); check("R9", filt_o[2], 1'b1);

    // R3 tick pacing with interval 1
    wr(4'd4, 8'h01); wr(4'd12, 8'h01);
    raw_i[4] = 1'b1; cyc(2);
    cyc(DIV + 2);
    check("R3", filt_o[4], 1'b1);

    // R10 readback with mixed filtered and unfiltered channels
    raw_i[23:16] = 8'h5A; cyc(3);
    rd(4'd2, d); check("R10", d, 8'h5A);
    rd(4'd0, d); check("R10", d, m_filt() & 24'hFF);

    cyc(5);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule